// File: doc/BRIEF.md
# Token-Ring Cascadable FIFO Slice

This block is one slice of a deep FIFO that is built by chaining identical slices in a ring. Each slice has its own small memory. Two tokens go around the ring, one for writing and one for reading. The slice that holds the write token takes the incoming words. The slice that holds the read token presents the oldest word. When the write-token holder fills the last location of its memory, it passes the write token to the next slice. The read token moves the same way when its holder pops its last location. The ring therefore behaves as a single FIFO of depth slices × DEPTH, and no arbitration logic is needed outside the slices.

After reset, the slice whose lead strap is tied low owns both tokens. The strap is tied high on every other slice. The token output of each slice is wired to the token input of the next slice, and the last slice feeds back to the first. All slices share one clock. Every slice sees the same write data, enables and read enable. Only the read-token holder drives a non-zero word onto its read data output, so the outputs of all slices can be ORed into one shared bus.

Top module: `tokenCascSlice`

## Requirements
- R1: During and after reset, a slice with `ringLeadN` low holds both tokens with an empty memory, and a slice with `ringLeadN` high holds neither.
- R2: A write is stored only by the write-token holder, and only when `wrEn` is high and that slice is not full. Words leave the ring in the order they were written, across all slices.
- R3: When the write-token holder stores into its last location (index DEPTH-1), `wrTokOut` is high in that same cycle only. A slice with `wrTokIn` high at a clock edge holds the write token after that edge. The sender has given the token up after that edge.
- R4: When the read-token holder pops its last location, `rdTokOut` is high in that same cycle only. A slice with `rdTokIn` high at an edge holds the read token after that edge. The sender has given it up.
- R5: `rdDrive` is high only on the read-token holder. `rdData` is all zeros on every other slice.
- R6: Show-ahead output: while the read-token holder's memory is not empty, its `rdData` equals the oldest unread word of the whole ring, and `rdEn` pops it at the next edge.
- R7: When the write-token holder's memory is full (the whole ring is full), `sliceFull` is high on that slice. A write in that cycle is ignored and changes no stored word.
- R8: When the read-token holder's memory is empty (the whole ring is empty), `sliceEmpty` is high on that slice. A read in that cycle is ignored.
- R9: A write and a read in the same cycle both take effect when neither is blocked by R7 or R8. This holds when the same slice holds both tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices |
| rstN | input | 1 | Active-low synchronous reset |
| ringLeadN | input | 1 | Lead strap: low on the slice that starts with both tokens |
| wrEn | input | 1 | Write request, shared by all slices |
| wrData | input | DATA_W | Write word, shared by all slices |
| rdEn | input | 1 | Read (pop) request, shared by all slices |
| rdData | output | DATA_W | Oldest word when this slice holds the read token, zero otherwise |
| rdDrive | output | 1 | High while this slice holds the read token |
| sliceFull | output | 1 | High while this slice holds the write token and its memory is full |
| sliceEmpty | output | 1 | High while this slice holds the read token and its memory is empty |
| wrTokIn | input | 1 | Write-token handover from the previous slice |
| wrTokOut | output | 1 | Write-token handover to the next slice |
| rdTokIn | input | 1 | Read-token handover from the previous slice |
| rdTokOut | output | 1 | Read-token handover to the next slice |

## Verification
Three slices of depth four are joined in a ring. A behavioural queue predicts the shared output, the flags, which slice drives and which slice pulses its token outputs in each cycle. A write-only burst past capacity separates correct full blocking from lost or overwritten words. A read-only drain past empty separates correct empty blocking from phantom pops. Streaming with both enables high carries both tokens around the ring several times, which exposes off-by-one handovers and wrong wrap points. Random mixed traffic covers a reader that chases the writer, and handovers that happen while the same slice holds both tokens.

// File: rtl/tokenCascPkg.sv
package tokenCascPkg;
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } sliceStrobes_t;
endpackage

// File: rtl/tokenCascCtrl.sv
module tokenCascCtrl
  import tokenCascPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic ringLeadN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic wrAtEnd,
  input  logic rdAtEnd,
  input  logic wrTokIn,
  input  logic rdTokIn,
  output logic holdsWr,
  output logic holdsRd,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic isFull,
  output logic isEmpty,
  output logic wrTokOut,
  output logic rdTokOut,
  output sliceStrobes_t strobes
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assign isFull  = (fillLevel == FULL_CNT);
  assign isEmpty = (fillLevel == '0);

  always_comb begin
    strobes.doWrite = holdsWr && wrEn && !isFull;
    strobes.doRead  = holdsRd && rdEn && !isEmpty;
  end

  // handover is combinational so the next slice owns the token one edge later
  assign wrTokOut = strobes.doWrite && wrAtEnd;
  assign rdTokOut = strobes.doRead && rdAtEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdsWr   <= !ringLeadN;
      holdsRd   <= !ringLeadN;
      fillLevel <= '0;
    end else begin
      if (wrTokIn)       holdsWr <= 1'b1;
      else if (wrTokOut) holdsWr <= 1'b0;
      if (rdTokIn)       holdsRd <= 1'b1;
      else if (rdTokOut) holdsRd <= 1'b0;
      case ({strobes.doWrite, strobes.doRead})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
    end
  end
endmodule

// File: rtl/tokenCascData.sv
module tokenCascData
  import tokenCascPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sliceStrobes_t     strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headWord,
  output logic              wrAtEnd,
  output logic              rdAtEnd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  assign wrAtEnd  = (wrPtr == LAST_PTR);
  assign rdAtEnd  = (rdPtr == LAST_PTR);
  assign headWord = store[rdPtr];

  always_ff @(posedge clk) begin
    if (strobes.doWrite) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.doWrite) wrPtr <= wrAtEnd ? '0 : wrPtr + 1'b1;
      if (strobes.doRead)  rdPtr <= rdAtEnd ? '0 : rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tokenCascSlice.sv
module tokenCascSlice
  import tokenCascPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringLeadN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              sliceFull,
  output logic              sliceEmpty,
  input  logic              wrTokIn,
  output logic              wrTokOut,
  input  logic              rdTokIn,
  output logic              rdTokOut
);
  localparam int CNT_W = $clog2(DEPTH+1);

  sliceStrobes_t     strobes;
  logic              holdsWr, holdsRd, isFull, isEmpty, wrAtEnd, rdAtEnd;
  logic [CNT_W-1:0]  fillLevel;
  logic [DATA_W-1:0] headWord;

  tokenCascCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .ringLeadN(ringLeadN),
    .wrEn(wrEn), .rdEn(rdEn), .wrAtEnd(wrAtEnd), .rdAtEnd(rdAtEnd),
    .wrTokIn(wrTokIn), .rdTokIn(rdTokIn),
    .holdsWr(holdsWr), .holdsRd(holdsRd), .fillLevel(fillLevel),
    .isFull(isFull), .isEmpty(isEmpty),
    .wrTokOut(wrTokOut), .rdTokOut(rdTokOut), .strobes(strobes)
  );

  tokenCascData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .headWord(headWord), .wrAtEnd(wrAtEnd), .rdAtEnd(rdAtEnd)
  );

  assign rdDrive    = holdsRd;
  assign rdData     = holdsRd ? headWord : '0;
  assign sliceFull  = holdsWr && isFull;
  assign sliceEmpty = holdsRd && isEmpty;
endmodule

// File: rtl/tokenCascChecker.sv
module tokenCascChecker
  import tokenCascPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrTokIn,
  input logic                       wrTokOut,
  input logic                       rdTokIn,
  input logic                       rdTokOut,
  input logic                       holdsWr,
  input logic                       holdsRd,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel,
  input sliceStrobes_t              strobes,
  input logic [DATA_W-1:0]          rdData
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_take_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrTokIn |=> holdsWr);
  p_drop_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrTokOut && !wrTokIn) |=> !holdsWr);
  p_take_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdTokIn |=> holdsRd);
  p_drop_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdTokOut && !rdTokIn) |=> !holdsRd);
  p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    !holdsRd |-> (rdData == '0));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == FULL_CNT && !strobes.doRead) |=> (fillLevel == FULL_CNT));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && !strobes.doWrite) |=> (fillLevel == '0));
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_CNT);
endmodule

bind tokenCascSlice tokenCascChecker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrTokIn(wrTokIn), .wrTokOut(wrTokOut),
  .rdTokIn(rdTokIn), .rdTokOut(rdTokOut), .holdsWr(holdsWr),
  .holdsRd(holdsRd), .fillLevel(fillLevel), .strobes(strobes), .rdData(rdData)
);

// File: tb/test_tokenCascSlice.sv
`timescale 1ns/1ps
module test_tokenCascSlice;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int DW = 9;
  localparam int CAP = N * D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdDataS [N];
  logic [N-1:0] rdDrive, sFull, sEmpty, wrTok, rdTok;

  int checks = 0, errors = 0;
  int q[$];
  int nWr = 0, nRd = 0, nextWord = 1;

  always #10 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_slice
    tokenCascSlice #(.DATA_W(DW), .DEPTH(D)) i_tokenCascSlice (
      .clk(clk), .rstN(rstN), .ringLeadN(i != 0),
      .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
      .rdData(rdDataS[i]), .rdDrive(rdDrive[i]),
      .sliceFull(sFull[i]), .sliceEmpty(sEmpty[i]),
      .wrTokIn(wrTok[(i+N-1)%N]), .wrTokOut(wrTok[i]),
      .rdTokIn(rdTok[(i+N-1)%N]), .rdTokOut(rdTok[i])
    );
  end

  logic [DW-1:0] bus;
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | rdDataS[i];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // state checks, called away from the clock edge
  task automatic checkState();
    int rdH;
    rdH = (nRd / D) % N;
    check(rdDrive == N'(1 << rdH), "R5 drive", rdDrive, 1 << rdH);
    check(|sFull == (q.size() == CAP), "R7 full", |sFull, q.size() == CAP);
    check(|sEmpty == (q.size() == 0), "R8 empty", |sEmpty, q.size() == 0);
    if (q.size() > 0) check(bus == DW'(q[0]), "R6 head", bus, q[0]);
    else check(bus == rdDataS[rdH], "R5 quiet", bus, rdDataS[rdH]);
  endtask

  task automatic step(input bit we, input bit re);
    bit aw, ar;
    int wrH, rdH, expW, expR;
    @(negedge clk);
    checkState();
    wrEn = we; rdEn = re; wrData = DW'(nextWord);
    aw = we && (q.size() < CAP);
    ar = re && (q.size() > 0);
    wrH = (nWr / D) % N;
    rdH = (nRd / D) % N;
    expW = (aw && (nWr % D == D-1)) ? (1 << wrH) : 0;
    expR = (ar && (nRd % D == D-1)) ? (1 << rdH) : 0;
    #1;
    check(wrTok == N'(expW), "R3 wr token pulse", wrTok, expW);
    check(rdTok == N'(expR), "R4 rd token pulse", rdTok, expR);
    @(posedge clk);
    if (ar) begin void'(q.pop_front()); nRd++; end
    if (aw) begin q.push_back(nextWord); nWr++; nextWord = (nextWord % 500) + 1; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: lead slice starts with both tokens and empty ring
    check(rdDrive == 3'b001, "R1 reset read token", rdDrive, 1);
    check(sEmpty == 3'b001 && sFull == 3'b000, "R1 reset flags", sEmpty, 1);
    rstN = 1'b1;
    // R2/R3/R7: write past capacity
    for (int k = 0; k < CAP + 3; k++) step(1, 0);
    // R4/R8: drain past empty
    for (int k = 0; k < CAP + 3; k++) step(0, 1);
    // R9: streaming with both enables, tokens circle the ring
    for (int k = 0; k < 5; k++) step(1, 0);
    for (int k = 0; k < 40; k++) step(1, 1);
    // R9 with writer and reader in one slice, and random mixes
    for (int k = 0; k < 600; k++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    for (int k = 0; k < 300; k++) step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0);
    for (int k = 0; k < 300; k++) step($urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
    @(negedge clk);
    checkState();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule